// File: doc/BRIEF.md
# Ethernet PHY Basic Control Register with MII Datapath Gating

This block holds the basic control register of a 10/100 Ethernet PHY's management space and applies its settings directly to the MII datapath. A management agent reads and writes the register through a plain address/data/strobe port. The register's power-on values come from four strap inputs: autonegotiation enable, 100 Mb/s full-duplex ability, 100 Mb/s half-duplex ability and isolate. Each strap passes through a two-flop synchronizer before use. The isolate control also follows later level changes on its strap.

The register's fields steer the transmit and receive nibble paths. Loopback sends the MAC's transmit nibble, enable and error back to its receive side and keeps the line transmitter idle. Isolate and powerdown silence both directions and drop a single output-enable that tri-states the MII outputs. The resolved link speed is taken from the speed field, or from the autonegotiation result whenever autonegotiation is enabled.

Top module: `phy_ctrl_reg`

## Requirements
- R1: On reset the control bits load, within five rising clock edges of reset release, as follows. Loop (bit 14) and powerdown (bit 11) load 0. Autonegotiation enable (bit 12) loads the autonegotiation strap. Isolate (bit 10) loads the isolate strap. Speed (bit 13) loads 1, unless the autonegotiation strap is 1 or both 100 Mb/s straps are 0, in which case it loads 0.
- R2: Reading address 0 returns the bits at these positions: loop at 14, speed at 13, autonegotiation at 12, powerdown at 11 and isolate at 10. Bit 15 and bits 9 to 0 read 0. Every other address reads 0.
- R3: A write to address 0 updates bits 14 to 10 on the next rising edge. Write data bits 9 to 0 are ignored. Writes to any other address leave the register unchanged.
- R4: A write to address 0 with bit 15 set reloads the R1 defaults from the current synchronized straps on that edge, and bit 15 reads back 0.
- R5: After reset, each level change of the isolate strap copies the new level into bit 10, within five edges of the change. Between strap changes, a management write may set bit 10 to any value, and that value holds until the next strap change.
- R6: The speed100 output equals the aneg_speed100 input while bit 12 is 1, and equals bit 13 while bit 12 is 0.
- R7: While bit 10 or bit 11 is 1, all of the following hold: mii_oe is 0, the line transmit outputs are 0, the MAC receive outputs are 0, and MAC transmit inputs have no effect.
- R8: While bit 14 is 1, bit 12 is 0 and the block is not gated by R7, mac_rxd/mac_rxdv/mac_rxer follow mac_txd/mac_txen/mac_txer, the line transmit outputs are 0, and loop_on is 1.
- R9: While bit 14 is 1 and bit 12 is 1, loopback is not applied: loop_on is 0 and the datapath behaves as in R10.
- R10: With no isolate, powerdown or loopback in effect, mii_oe is 1, the line transmit outputs follow the MAC transmit inputs, and the MAC receive outputs follow the line receive inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mgmt_addr | input | 5 | Management register address |
| mgmt_wdata | input | 16 | Management write data |
| mgmt_we | input | 1 | Management write strobe |
| mgmt_rdata | output | 16 | Management read data (combinational on address) |
| strap_aneg | input | 1 | Autonegotiation enable strap |
| strap_fd100 | input | 1 | 100 Mb/s full-duplex strap |
| strap_hd100 | input | 1 | 100 Mb/s half-duplex strap |
| strap_iso | input | 1 | Isolate strap |
| aneg_speed100 | input | 1 | Autonegotiation speed result, 1 = 100 Mb/s |
| mac_txd | input | 4 | MAC transmit nibble |
| mac_txen | input | 1 | MAC transmit enable |
| mac_txer | input | 1 | MAC transmit error |
| mac_rxd | output | 4 | Receive nibble toward the MAC |
| mac_rxdv | output | 1 | Receive data valid toward the MAC |
| mac_rxer | output | 1 | Receive error toward the MAC |
| line_txd | output | 4 | Transmit nibble toward the line coder |
| line_txen | output | 1 | Transmit enable toward the line coder |
| line_txer | output | 1 | Transmit error toward the line coder |
| line_rxd | input | 4 | Receive nibble from the line decoder |
| line_rxdv | input | 1 | Receive valid from the line decoder |
| line_rxer | input | 1 | Receive error from the line decoder |
| mii_oe | output | 1 | Output enable for all MII outputs, 0 = high impedance |
| speed100 | output | 1 | Resolved speed, 1 = 100 Mb/s |
| loop_on | output | 1 | Loopback path selected |

## Verification
The datapath is driven with distinct nibbles on the MAC transmit side and on the line receive side. This makes it visible whether each output carries passthrough, looped-back or zeroed data. Three strap combinations are tried: speed default 1; autonegotiation plus isolate; and neither 100 Mb/s strap. Together they separate the speed-default rule from plain strap copying. The isolate strap is toggled before and after a management write, which shows that the pin edge takes effect and that the write override holds. Loopback is tried with autonegotiation both off and on, and speed resolution is tried with the autonegotiation result both agreeing and disagreeing with the speed bit.

// File: rtl/phy_ctrl_pkg.sv
package phy_ctrl_pkg;
  localparam int BIT_RST  = 15;
  localparam int BIT_LOOP = 14;
  localparam int BIT_SPD  = 13;
  localparam int BIT_ANEG = 12;
  localparam int BIT_PDN  = 11;
  localparam int BIT_ISO  = 10;

  localparam int STRAP_N    = 4;
  localparam int STRAP_ANEG = 0;
  localparam int STRAP_FD   = 1;
  localparam int STRAP_HD   = 2;
  localparam int STRAP_ISO  = 3;

  typedef struct packed {
    logic loop;
    logic spd100;
    logic aneg;
    logic pdn;
    logic iso;
  } ctrl_t;

  function automatic ctrl_t strap_defaults(input logic [STRAP_N-1:0] s);
    ctrl_t c;
    c.loop   = 1'b0;
    c.pdn    = 1'b0;
    c.aneg   = s[STRAP_ANEG];
    c.iso    = s[STRAP_ISO];
    c.spd100 = ~(s[STRAP_ANEG] | (~s[STRAP_FD] & ~s[STRAP_HD]));
    return c;
  endfunction
endpackage

// File: rtl/strap_sync.sv
module strap_sync #(
  parameter int N      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] pin_i,
  output logic [N-1:0] sync_o
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    logic [STAGES-1:0] sh_q, sh_d;
    always_comb sh_d = {sh_q[STAGES-2:0], pin_i[i]};
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sh_q <= '0;
      else        sh_q <= sh_d;
    end
    assign sync_o[i] = sh_q[STAGES-1];
  end
endmodule

// File: rtl/ctrl_regfile.sv
module ctrl_regfile
  import phy_ctrl_pkg::*;
#(
  parameter int ADDR_W   = 5,
  parameter int DATA_W   = 16,
  parameter int REG_ADDR = 0,
  parameter int STAGES   = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [DATA_W-1:0]  wdata_i,
  input  logic               we_i,
  input  logic [STRAP_N-1:0] strap_s_i,
  output ctrl_t              ctrl_o,
  output logic [DATA_W-1:0]  rdata_o
);
  localparam int CNT_W    = $clog2(STAGES + 2);
  localparam int CNT_LOAD = STAGES;
  localparam int CNT_DONE = STAGES + 1;

  ctrl_t            ctrl_q, ctrl_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             iso_prev_q, iso_prev_d;
  logic             ctrl_en, cnt_en;
  logic             sel, sw_rst, init_load, init_done, iso_edge;
  logic             unused_wdata;

  assign sel          = we_i && (addr_i == ADDR_W'(REG_ADDR));
  assign sw_rst       = sel && wdata_i[BIT_RST];
  assign init_load    = (cnt_q == CNT_W'(CNT_LOAD));
  assign init_done    = (cnt_q == CNT_W'(CNT_DONE));
  assign iso_edge     = init_done && (strap_s_i[STRAP_ISO] != iso_prev_q);
  assign unused_wdata = ^wdata_i[BIT_ISO-1:0];

  // Next state: reload beats write, write beats a strap edge on isolate.
  always_comb begin
    ctrl_d     = ctrl_q;
    cnt_d      = cnt_q + CNT_W'(1);
    iso_prev_d = strap_s_i[STRAP_ISO];
    cnt_en     = !init_done;
    ctrl_en    = init_load || sel || iso_edge;
    if (init_load || sw_rst) begin
      ctrl_d = strap_defaults(strap_s_i);
    end else if (sel) begin
      ctrl_d.loop   = wdata_i[BIT_LOOP];
      ctrl_d.spd100 = wdata_i[BIT_SPD];
      ctrl_d.aneg   = wdata_i[BIT_ANEG];
      ctrl_d.pdn    = wdata_i[BIT_PDN];
      ctrl_d.iso    = wdata_i[BIT_ISO];
    end else if (iso_edge) begin
      ctrl_d.iso = strap_s_i[STRAP_ISO];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q     <= '0;
      cnt_q      <= '0;
      iso_prev_q <= 1'b0;
    end else begin
      if (ctrl_en) ctrl_q <= ctrl_d;
      if (cnt_en)  cnt_q  <= cnt_d;
      iso_prev_q <= iso_prev_d;
    end
  end

  always_comb begin
    rdata_o = '0;
    if (addr_i == ADDR_W'(REG_ADDR)) begin
      rdata_o[BIT_LOOP] = ctrl_q.loop;
      rdata_o[BIT_SPD]  = ctrl_q.spd100;
      rdata_o[BIT_ANEG] = ctrl_q.aneg;
      rdata_o[BIT_PDN]  = ctrl_q.pdn;
      rdata_o[BIT_ISO]  = ctrl_q.iso;
    end
  end

  assign ctrl_o = ctrl_q;

  // R4: software reload clears powerdown and loop
  a_r4_swreset_clears: assert property (@(posedge clk) disable iff (!rst_n)
    sw_rst |=> (!ctrl_q.pdn && !ctrl_q.loop));
  // R3: writes elsewhere leave the register alone
  a_r3_other_addr_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (we_i && !sel && !init_load && !iso_edge) |=> $stable(ctrl_q));
  // R5: an unopposed strap edge lands in the isolate bit
  a_r5_iso_follows_pin: assert property (@(posedge clk) disable iff (!rst_n)
    (iso_edge && !sel) |=> (ctrl_q.iso == $past(strap_s_i[STRAP_ISO])));
endmodule

// File: rtl/mii_gate.sv
module mii_gate
  import phy_ctrl_pkg::*;
#(
  parameter int NIB_W = 4
) (
  input  ctrl_t            ctrl_i,
  input  logic             aneg_speed100_i,
  input  logic [NIB_W-1:0] mac_txd_i,
  input  logic             mac_txen_i,
  input  logic             mac_txer_i,
  input  logic [NIB_W-1:0] line_rxd_i,
  input  logic             line_rxdv_i,
  input  logic             line_rxer_i,
  output logic [NIB_W-1:0] line_txd_o,
  output logic             line_txen_o,
  output logic             line_txer_o,
  output logic [NIB_W-1:0] mac_rxd_o,
  output logic             mac_rxdv_o,
  output logic             mac_rxer_o,
  output logic             mii_oe_o,
  output logic             speed100_o,
  output logic             loop_on_o
);
  logic gated, loop_act;

  assign gated      = ctrl_i.pdn | ctrl_i.iso;
  assign loop_act   = ctrl_i.loop & ~ctrl_i.aneg & ~gated;
  assign mii_oe_o   = ~gated;
  assign loop_on_o  = loop_act;
  assign speed100_o = ctrl_i.aneg ? aneg_speed100_i : ctrl_i.spd100;

  always_comb begin
    line_txd_o  = '0;
    line_txen_o = 1'b0;
    line_txer_o = 1'b0;
    mac_rxd_o   = '0;
    mac_rxdv_o  = 1'b0;
    mac_rxer_o  = 1'b0;
    if (!gated) begin
      if (loop_act) begin
        mac_rxd_o  = mac_txd_i;
        mac_rxdv_o = mac_txen_i;
        mac_rxer_o = mac_txer_i;
      end else begin
        line_txd_o  = mac_txd_i;
        line_txen_o = mac_txen_i;
        line_txer_o = mac_txer_i;
        mac_rxd_o   = line_rxd_i;
        mac_rxdv_o  = line_rxdv_i;
        mac_rxer_o  = line_rxer_i;
      end
    end
  end
endmodule

// File: rtl/phy_ctrl_reg.sv
module phy_ctrl_reg
  import phy_ctrl_pkg::*;
#(
  parameter int ADDR_W      = 5,
  parameter int DATA_W      = 16,
  parameter int NIB_W       = 4,
  parameter int REG_ADDR    = 0,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] mgmt_addr,
  input  logic [DATA_W-1:0] mgmt_wdata,
  input  logic              mgmt_we,
  output logic [DATA_W-1:0] mgmt_rdata,
  input  logic              strap_aneg,
  input  logic              strap_fd100,
  input  logic              strap_hd100,
  input  logic              strap_iso,
  input  logic              aneg_speed100,
  input  logic [NIB_W-1:0]  mac_txd,
  input  logic              mac_txen,
  input  logic              mac_txer,
  output logic [NIB_W-1:0]  mac_rxd,
  output logic              mac_rxdv,
  output logic              mac_rxer,
  output logic [NIB_W-1:0]  line_txd,
  output logic              line_txen,
  output logic              line_txer,
  input  logic [NIB_W-1:0]  line_rxd,
  input  logic              line_rxdv,
  input  logic              line_rxer,
  output logic              mii_oe,
  output logic              speed100,
  output logic              loop_on
);
  logic [STRAP_N-1:0] strap_raw, strap_s;
  ctrl_t              ctrl;

  always_comb begin
    strap_raw             = '0;
    strap_raw[STRAP_ANEG] = strap_aneg;
    strap_raw[STRAP_FD]   = strap_fd100;
    strap_raw[STRAP_HD]   = strap_hd100;
    strap_raw[STRAP_ISO]  = strap_iso;
  end

  strap_sync #(.N(STRAP_N), .STAGES(SYNC_STAGES)) i_sync (
    .clk(clk), .rst_n(rst_n), .pin_i(strap_raw), .sync_o(strap_s)
  );

  ctrl_regfile #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .REG_ADDR(REG_ADDR), .STAGES(SYNC_STAGES)
  ) i_regs (
    .clk(clk), .rst_n(rst_n), .addr_i(mgmt_addr), .wdata_i(mgmt_wdata),
    .we_i(mgmt_we), .strap_s_i(strap_s), .ctrl_o(ctrl), .rdata_o(mgmt_rdata)
  );

  mii_gate #(.NIB_W(NIB_W)) i_gate (
    .ctrl_i(ctrl), .aneg_speed100_i(aneg_speed100),
    .mac_txd_i(mac_txd), .mac_txen_i(mac_txen), .mac_txer_i(mac_txer),
    .line_rxd_i(line_rxd), .line_rxdv_i(line_rxdv), .line_rxer_i(line_rxer),
    .line_txd_o(line_txd), .line_txen_o(line_txen), .line_txer_o(line_txer),
    .mac_rxd_o(mac_rxd), .mac_rxdv_o(mac_rxdv), .mac_rxer_o(mac_rxer),
    .mii_oe_o(mii_oe), .speed100_o(speed100), .loop_on_o(loop_on)
  );

  // R7: a disabled MII carries nothing either way
  a_r7_quiet_when_gated: assert property (@(posedge clk) disable iff (!rst_n)
    !mii_oe |-> (!line_txen && !line_txer && !mac_rxdv && !mac_rxer));
  // R8: loopback mirrors transmit onto receive with the line idle
  a_r8_loop_mirror: assert property (@(posedge clk) disable iff (!rst_n)
    loop_on |-> (mac_rxd == mac_txd && mac_rxdv == mac_txen && !line_txen));
  // R10: normal passthrough in both directions
  a_r10_passthrough: assert property (@(posedge clk) disable iff (!rst_n)
    (mii_oe && !loop_on) |-> (line_txd == mac_txd && mac_rxd == line_rxd));
endmodule

// File: tb/test_phy_ctrl_reg.sv
`timescale 1ns/1ps
module test_phy_ctrl_reg;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  mgmt_addr = '0;
  logic [15:0] mgmt_wdata = '0;
  logic        mgmt_we = 1'b0;
  logic [15:0] mgmt_rdata;
  logic        strap_aneg = 0, strap_fd100 = 1, strap_hd100 = 0, strap_iso = 0;
  logic        aneg_speed100 = 0;
  logic [3:0]  mac_txd = 4'h0, line_rxd = 4'h0;
  logic        mac_txen = 0, mac_txer = 0, line_rxdv = 0, line_rxer = 0;
  logic [3:0]  mac_rxd, line_txd;
  logic        mac_rxdv, mac_rxer, line_txen, line_txer, mii_oe, speed100, loop_on;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  phy_ctrl_reg i_phy_ctrl_reg (.*);

  task automatic check(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    check(act === exp, req, act, exp);
  endtask

  task automatic cycles(input int n);
    for (int i = 0; i < n; i++) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [4:0] a, input logic [15:0] d);
    @(negedge clk);
    mgmt_addr = a; mgmt_wdata = d; mgmt_we = 1'b1;
    @(posedge clk);
    @(negedge clk);
    mgmt_we = 1'b0; mgmt_addr = 5'd0;
  endtask

  task automatic do_reset(input logic an, input logic fd, input logic hd, input logic iso);
    @(negedge clk);
    rst_n = 1'b0;
    strap_aneg = an; strap_fd100 = fd; strap_hd100 = hd; strap_iso = iso;
    cycles(3);
    rst_n = 1'b1;
    cycles(5);
  endtask

  task automatic t_reset_default_a;
    do_reset(0, 1, 0, 0);
    mgmt_addr = 5'd0;
    chk("R1 defaults straps an0 fd1 hd0 iso0", mgmt_rdata, 16'h2000);
    chk("R1 R10 mii_oe after reset", {15'd0, mii_oe}, 16'd1);
    chk("R6 speed from bit13 after reset", {15'd0, speed100}, 16'd1);
  endtask

  task automatic t_write_and_loop;
    wr(5'd0, 16'h63FF);
    chk("R3 write ignores bits 9:0", mgmt_rdata, 16'h6000);
    mac_txd = 4'hA; mac_txen = 1; mac_txer = 0;
    line_rxd = 4'h5; line_rxdv = 0; line_rxer = 1;
    #1;
    chk("R8 loop_on", {15'd0, loop_on}, 16'd1);
    chk("R8 mac_rxd mirrors mac_txd", {12'd0, mac_rxd}, 16'h000A);
    chk("R8 rxdv/rxer mirror txen/txer", {14'd0, mac_rxdv, mac_rxer}, 16'h0002);
    chk("R8 line tx idle", {10'd0, line_txd, line_txen, line_txer}, 16'h0000);
  endtask

  task automatic t_other_address;
    wr(5'd3, 16'h0800);
    mgmt_addr = 5'd0; #1;
    chk("R3 write to other address ignored", mgmt_rdata, 16'h6000);
    mgmt_addr = 5'd3; #1;
    chk("R2 other address reads 0", mgmt_rdata, 16'h0000);
    mgmt_addr = 5'd0;
  endtask

  task automatic t_loop_with_aneg;
    wr(5'd0, 16'h5000);
    mac_txd = 4'h3; mac_txen = 1; mac_txer = 1;
    line_rxd = 4'hC; line_rxdv = 1; line_rxer = 0;
    aneg_speed100 = 0; #1;
    chk("R9 loop_on off under aneg", {15'd0, loop_on}, 16'd0);
    chk("R9 line_txd passes", {12'd0, line_txd}, 16'h0003);
    chk("R9 mac_rxd from line", {12'd0, mac_rxd}, 16'h000C);
    chk("R6 aneg result 0", {15'd0, speed100}, 16'd0);
    aneg_speed100 = 1; #1;
    chk("R6 aneg result 1", {15'd0, speed100}, 16'd1);
  endtask

  task automatic t_speed_manual;
    aneg_speed100 = 0;
    wr(5'd0, 16'h2000);
    chk("R6 bit13=1 beats aneg result", {15'd0, speed100}, 16'd1);
    aneg_speed100 = 1;
    wr(5'd0, 16'h0000);
    chk("R6 bit13=0 beats aneg result", {15'd0, speed100}, 16'd0);
  endtask

  task automatic t_powerdown;
    mac_txd = 4'h9; mac_txen = 1; mac_txer = 1;
    line_rxd = 4'h6; line_rxdv = 1; line_rxer = 1;
    wr(5'd0, 16'h0800);
    chk("R7 powerdown mii_oe", {15'd0, mii_oe}, 16'd0);
    chk("R7 powerdown line tx zero", {10'd0, line_txd, line_txen, line_txer}, 16'h0000);
    chk("R7 powerdown mac rx zero", {10'd0, mac_rxd, mac_rxdv, mac_rxer}, 16'h0000);
    wr(5'd0, 16'h0000);
    chk("R10 passthrough tx", {10'd0, line_txd, line_txen, line_txer}, 16'h0027);
    chk("R10 passthrough rx", {10'd0, mac_rxd, mac_rxdv, mac_rxer}, 16'h001B);
    chk("R10 mii_oe", {15'd0, mii_oe}, 16'd1);
  endtask

  task automatic t_isolate_pin;
    strap_iso = 1;
    cycles(5);
    chk("R5 pin rise sets isolate", mgmt_rdata, 16'h0400);
    chk("R7 isolate mii_oe", {15'd0, mii_oe}, 16'd0);
    chk("R7 isolate line tx zero", {10'd0, line_txd, line_txen, line_txer}, 16'h0000);
    wr(5'd0, 16'h0000);
    cycles(3);
    chk("R5 write overrides between edges", mgmt_rdata, 16'h0000);
    strap_iso = 0;
    cycles(5);
    chk("R5 pin fall keeps 0", mgmt_rdata, 16'h0000);
    strap_iso = 1;
    cycles(5);
    chk("R5 second rise sets isolate", mgmt_rdata, 16'h0400);
  endtask

  task automatic t_sw_reset;
    wr(5'd0, 16'h4800);
    chk("R3 setup before reload", mgmt_rdata, 16'h4800);
    wr(5'd0, 16'h8800);
    chk("R4 reload defaults, bit15 reads 0", mgmt_rdata, 16'h2400);
  endtask

  task automatic t_reset_b_c;
    aneg_speed100 = 1;
    do_reset(1, 1, 1, 1);
    chk("R1 defaults straps an1 fd1 hd1 iso1", mgmt_rdata, 16'h1400);
    chk("R6 speed from aneg after reset", {15'd0, speed100}, 16'd1);
    do_reset(0, 0, 0, 0);
    chk("R1 defaults straps an0 fd0 hd0 iso0", mgmt_rdata, 16'h0000);
    chk("R6 speed 0 with no 100 straps", {15'd0, speed100}, 16'd0);
  endtask

  initial begin
    t_reset_default_a();
    t_write_and_loop();
    t_other_address();
    t_loop_with_aneg();
    t_speed_manual();
    t_powerdown();
    t_isolate_pin();
    t_sw_reset();
    t_reset_b_c();
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #1ms;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule